// File: doc/BRIEF.md
# Iterative CORDIC hyperbolic tangent unit

This block computes tanh(x) for one signed fixed-point sample at a time. A single shift-add datapath with three adders is reused for every step of the computation. It first runs hyperbolic rotation to form cosh and sinh of a reduced argument. The same adders then combine those values and run linear vectoring to divide them. A small scheduler sequences the phases. Neither the rotation nor the division is unrolled.

Inputs arrive on a ready/valid handshake. The block takes a sample only when it is idle. It then stays busy until it has produced a result, which it marks with a one-cycle strobe. Magnitudes above ln2/2 are first reduced by whole multiples of ln2, and the 2^k factor this removes is restored by a shift before the division. Magnitudes large enough that tanh rounds to full scale bypass the datapath and return the largest code below one. The word length WL and the input fraction length FL are parameters. The output keeps WL bits and has WL-2 fraction bits.

Top module: `cordic_tanh`

## Requirements
- R1: A sample on x_i is taken only in a cycle where ready_o and valid_i are both high. valid_i while ready_o is low is ignored and has no effect on the result or on later strobes.
- R2: ready_o is high in the cycle that follows reset. It goes low on the edge that takes a sample, stays low up to and including the strobe cycle, and is high again in the cycle after the strobe.
- R3: valid_o is high for exactly one cycle per accepted sample.
- R4: Both rotation and division run N = max(WL-1, 7) steps each. The hyperbolic shift sequence starts at 1 and repeats shifts 4, 13 and 40.
- R5: y_o is two's complement, WL bits wide, with WL-2 fraction bits. For the default WL=16, FL=12, it lies within 4 LSB of round(tanh(x)·2^(WL-2)).
- R6: y_o for -x is exactly the negation of y_o for x.
- R7: When |x| > WL·ln2/2, y_o is exactly +(2^(WL-2)-1) for positive x or -(2^(WL-2)-1) for negative x. valid_o is then high 2 cycles after the capturing edge.
- R8: |y_o| never exceeds 2^(WL-2)-1.
- R9: After reset, y_o is 0 and valid_o is low. y_o holds its value from one strobe to the next.
- R10: Let m be the number of ln2 subtractions that bring |x| to at most ln2/2. For a non-saturated input, valid_o is high 2N+5+m cycles after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample on x_i is offered |
| x_i | input | WL | Signed input, FL fraction bits |
| ready_o | output | 1 | Block is idle and will take a sample |
| valid_o | output | 1 | One-cycle strobe marking y_o |
| y_o | output | WL | Signed tanh result, WL-2 fraction bits |

## Verification
With the default parameters N is 15. A non-saturated sample therefore strobes 35+m edges after the capturing edge, and a saturated sample strobes 2 edges after it. The bench raises valid_i at a falling edge. It counts rising edges from the capture and samples valid_o, ready_o and y_o only at falling edges. It works out m on its own by subtracting ln2 in real arithmetic, and it picks arguments that stay clear of the ln2/2 and saturation boundaries. ready_o is checked at every busy falling edge, and valid_o and ready_o are checked again at the falling edge after the strobe.

// File: rtl/cordic_tanh_pkg.sv
package cordic_tanh_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RED, S_ROT, S_PREP, S_SCALE, S_MERGE, S_DIV, S_FIN, S_DONE
  } state_e;

  function automatic int n_iter(int wl);
    return (wl - 1 < 7) ? 7 : wl - 1;
  endfunction

  // hyperbolic shift index for a step, repeats at 4, 13, 40
  function automatic int hyp_shift(int step);
    int  idx   = 1;
    bit  again = 1'b0;
    for (int s = 0; s < step; s++) begin
      if (!again && (idx == 4 || idx == 13 || idx == 40)) again = 1'b1;
      else begin
        again = 1'b0;
        idx++;
      end
    end
    return idx;
  endfunction

  function automatic real atanh_pow2(int i);
    real t;
    t = 2.0 ** (-i);
    return 0.5 * $ln((1.0 + t) / (1.0 - t));
  endfunction

  function automatic real inv_gain(int n);
    real g = 1.0;
    real t;
    for (int s = 0; s < n; s++) begin
      t = 2.0 ** (-2 * hyp_shift(s));
      g = g * $sqrt(1.0 - t);
    end
    return 1.0 / g;
  endfunction

  function automatic longint to_fix(real v, int fb);
    return longint'(v * (2.0 ** fb));
  endfunction

endpackage

// File: rtl/cordic_tanh_tab.sv
module cordic_tanh_tab import cordic_tanh_pkg::*; #(
  parameter int N   = 15,
  parameter int FB  = 18,
  parameter int DW  = 24,
  parameter int SHW = 7,
  localparam int SW = $clog2(N)
) (
  input  logic [SW-1:0]        step_i,
  input  logic                 lin_i,
  output logic [SHW-1:0]       sh_o,
  output logic signed [DW-1:0] ang_o
);
  localparam logic signed [DW-1:0] C_ONE = DW'(longint'(1) << FB);

  logic [SHW-1:0]       sh_rom  [N];
  logic signed [DW-1:0] ang_rom [N];

  for (genvar s = 0; s < N; s++) begin : g_rom
    localparam int     SH = hyp_shift(s);
    localparam longint AN = to_fix(atanh_pow2(SH), FB);
    assign sh_rom[s]  = SHW'(SH);
    assign ang_rom[s] = DW'(AN);
  end

  always_comb begin
    if (lin_i) begin
      sh_o  = SHW'(step_i);
      ang_o = C_ONE >>> step_i;
    end else begin
      sh_o  = sh_rom[step_i];
      ang_o = ang_rom[step_i];
    end
  end
endmodule

// File: rtl/cordic_tanh_ctrl.sv
module cordic_tanh_ctrl import cordic_tanh_pkg::*; #(
  parameter int N = 15,
  localparam int SW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          more_i,
  input  logic          sat_i,
  output state_e        state_o,
  output logic [SW-1:0] step_o
);
  state_e        state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic          last;

  assign last = step_q == SW'(N - 1);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      S_IDLE:  if (valid_i) state_d = S_RED;
      S_RED: begin
        if (sat_i)        state_d = S_FIN;
        else if (!more_i) begin
          state_d = S_ROT;
          step_d  = '0;
        end
      end
      S_ROT: begin
        step_d = step_q + 1'b1;
        if (last) begin
          state_d = S_PREP;
          step_d  = '0;
        end
      end
      S_PREP:  state_d = S_SCALE;
      S_SCALE: state_d = S_MERGE;
      S_MERGE: begin
        state_d = S_DIV;
        step_d  = '0;
      end
      S_DIV: begin
        step_d = step_q + 1'b1;
        if (last) begin
          state_d = S_FIN;
          step_d  = '0;
        end
      end
      S_FIN:   state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign state_o = state_q;
  assign step_o  = step_q;

  // R4: each iterative phase runs exactly N steps
  p_rot_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ROT && last) |=> state_q == S_PREP);
  p_div_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DIV && !last) |=> state_q == S_DIV);
  p_step_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= SW'(N - 1));
endmodule

// File: rtl/cordic_tanh_dp.sv
module cordic_tanh_dp import cordic_tanh_pkg::*; #(
  parameter int WL  = 16,
  parameter int FL  = 12,
  parameter int N   = 15,
  parameter int FB  = 18,
  parameter int DW  = 24,
  parameter int SHW = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  state_e               state_i,
  input  logic                 fire_i,
  input  logic [WL-1:0]        x_i,
  input  logic [SHW-1:0]       sh_tab_i,
  input  logic signed [DW-1:0] ang_tab_i,
  output logic                 more_o,
  output logic                 sat_o,
  output logic [WL-1:0]        y_o
);
  localparam int OFL = WL - 2;
  localparam int SC  = FB - FL;
  localparam int RS  = FB - OFL;
  localparam int KW  = SHW - 1;
  localparam logic signed [DW-1:0] C_LN2  = DW'(to_fix($ln(2.0), FB));
  localparam logic signed [DW-1:0] C_LN2H = DW'(to_fix($ln(2.0) / 2.0, FB));
  localparam logic signed [DW-1:0] C_SATZ = DW'(to_fix(WL * $ln(2.0) / 2.0, FB));
  localparam logic signed [DW-1:0] C_INVG = DW'(to_fix(inv_gain(N), FB));
  localparam logic signed [DW-1:0] C_HALF = DW'(longint'(1) << (RS - 1));
  localparam logic signed [DW-1:0] C_MAXC = DW'((longint'(1) << OFL) - 1);
  localparam logic signed [WL-1:0] OUT_MAX = WL'((longint'(1) << OFL) - 1);

  logic signed [DW-1:0] x_q, y_q, z_q;
  logic [KW-1:0]        k_q;
  logic                 neg_q, sat_q;
  logic signed [WL-1:0] res_q;

  logic signed [WL:0]   xe, mag;
  logic signed [DW-1:0] z_load;
  logic [SHW-1:0]       sh;
  logic signed [DW-1:0] ang, x_sh, y_sh, sum_x, sum_y, sum_z;
  logic                 dx, dy, dz;
  logic signed [DW-1:0] zr, mag_c, res_d, res_n;

  assign xe     = {x_i[WL-1], x_i};
  assign mag    = xe[WL] ? -xe : xe;
  assign z_load = {1'b0, mag, {SC{1'b0}}};

  always_comb begin
    unique case (state_i)
      S_SCALE:      sh = {k_q, 1'b0};
      S_ROT, S_DIV: sh = sh_tab_i;
      default:      sh = '0;
    endcase
    ang  = (state_i == S_RED) ? C_LN2 : ang_tab_i;
    x_sh = x_q >>> sh;
    y_sh = y_q >>> sh;
    dx = 1'b0;
    dy = 1'b0;
    dz = 1'b0;
    unique case (state_i)
      S_ROT: begin
        dx = ~z_q[DW-1];
        dy = ~z_q[DW-1];
        dz = z_q[DW-1];
      end
      S_DIV: begin
        dy = y_q[DW-1];
        dz = ~y_q[DW-1];
      end
      S_PREP:  dx = 1'b1;
      S_MERGE: dy = 1'b1;
      default: ;
    endcase
    sum_x = dx ? x_q + y_sh : x_q - y_sh;
    sum_y = dy ? y_q + x_sh : y_q - x_sh;
    sum_z = dz ? z_q + ang  : z_q - ang;
  end

  assign more_o = z_q > C_LN2H;
  assign sat_o  = z_q > C_SATZ;

  always_comb begin
    zr    = (z_q + C_HALF) >>> RS;
    mag_c = zr[DW-1] ? '0 : ((zr > C_MAXC) ? C_MAXC : zr);
    res_d = sat_q ? C_MAXC : mag_c;
    res_n = neg_q ? -res_d : res_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      k_q   <= '0;
      neg_q <= 1'b0;
      sat_q <= 1'b0;
      res_q <= '0;
    end else begin
      unique case (state_i)
        S_IDLE: if (fire_i) begin
          neg_q <= x_i[WL-1];
          z_q   <= z_load;
          k_q   <= '0;
          sat_q <= 1'b0;
        end
        S_RED: begin
          if (sat_o) sat_q <= 1'b1;
          else if (more_o) begin
            z_q <= sum_z;
            k_q <= k_q + 1'b1;
          end else begin
            x_q <= C_INVG;
            y_q <= '0;
          end
        end
        S_ROT: begin
          x_q <= sum_x;
          y_q <= sum_y;
          z_q <= sum_z;
        end
        S_PREP: begin
          x_q <= sum_x;  // e^r
          y_q <= sum_y;  // -e^-r
        end
        S_SCALE: y_q <= y_sh;
        S_MERGE: begin
          x_q <= sum_x;  // denominator
          y_q <= sum_y;  // numerator
          z_q <= '0;
        end
        S_DIV: begin
          y_q <= sum_y;
          z_q <= sum_z;
        end
        S_FIN:   res_q <= WL'(res_n);
        default: ;
      endcase
    end
  end

  assign y_o = res_q;

  p_sat_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_FIN && sat_q) |=> (res_q == OUT_MAX || res_q == -OUT_MAX));
  p_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_DONE) |-> (res_q <= OUT_MAX && res_q >= -OUT_MAX));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != S_FIN) |=> $stable(res_q));
endmodule

// File: rtl/cordic_tanh.sv
module cordic_tanh import cordic_tanh_pkg::*; #(
  parameter int WL = 16,
  parameter int FL = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [WL-1:0] x_i,
  output logic          ready_o,
  output logic          valid_o,
  output logic [WL-1:0] y_o
);
  localparam int N   = n_iter(WL);
  localparam int FB  = WL + 2;
  localparam int DW  = FB + WL - FL + 2;
  localparam int SHW = 7;
  localparam int SW  = $clog2(N);

  state_e               state;
  logic [SW-1:0]        step;
  logic                 more, sat, fire;
  logic [SHW-1:0]       sh_tab;
  logic signed [DW-1:0] ang_tab;

  assign ready_o = state == S_IDLE;
  assign valid_o = state == S_DONE;
  assign fire    = ready_o & valid_i;

  cordic_tanh_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .more_i (more),
    .sat_i  (sat),
    .state_o(state),
    .step_o (step)
  );

  cordic_tanh_tab #(.N(N), .FB(FB), .DW(DW), .SHW(SHW)) u_tab (
    .step_i(step),
    .lin_i (state == S_DIV),
    .sh_o  (sh_tab),
    .ang_o (ang_tab)
  );

  cordic_tanh_dp #(.WL(WL), .FL(FL), .N(N), .FB(FB), .DW(DW), .SHW(SHW)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .fire_i   (fire),
    .x_i      (x_i),
    .sh_tab_i (sh_tab),
    .ang_tab_i(ang_tab),
    .more_o   (more),
    .sat_o    (sat),
    .y_o      (y_o)
  );

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && valid_i) |=> !ready_o);
  p_busy_ignore_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !valid_o) |=> !ready_o);
  p_ready_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !ready_o);
  p_ready_back_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> ready_o);
  p_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: tb/cordic_tanh_tb.sv
`timescale 1ns/1ps
module cordic_tanh_tb;
  localparam int WL = 16;
  localparam int FL = 12;
  localparam int N  = 15;
  localparam int MAXC = 16383;
  localparam real LN2 = 0.6931471805599453;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [WL-1:0] x_i = '0;
  logic ready_o, valid_o;
  logic [WL-1:0] y_o;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cordic_tanh #(.WL(WL), .FL(FL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .x_i(x_i),
    .ready_o(ready_o), .valid_o(valid_o), .y_o(y_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int to_code(real x);
    return int'(x * 4096.0);
  endfunction

  function automatic int exp_tanh(int code);
    real x, e, t;
    int  r;
    x = code / 4096.0;
    e = $exp(2.0 * x);
    t = (e - 1.0) / (e + 1.0);
    r = int'(t * 16384.0);
    if (r > MAXC) r = MAXC;
    if (r < -MAXC) r = -MAXC;
    return r;
  endfunction

  function automatic int exp_lat(int code);
    real r;
    int  m = 0;
    r = (code < 0 ? -code : code) / 4096.0;
    if (r > WL * LN2 / 2.0) return 2;
    while (r > LN2 / 2.0) begin
      r = r - LN2;
      m++;
    end
    return 2 * N + 5 + m;
  endfunction

  // offers a sample, waits for the strobe; inj pulses valid_i while busy
  task automatic run(input int code, input bit inj, output int y, output int lat);
    bit busy_bad = 1'b0;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    valid_i = 1'b1;
    x_i = WL'(code);
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    x_i = '0;
    lat = 0;
    while (lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (inj && lat == 3) begin
        valid_i = 1'b1;
        x_i = 16'h9000;
      end else begin
        valid_i = 1'b0;
      end
      if (valid_o) break;
      if (ready_o) busy_bad = 1'b1;
    end
    y = int'($signed(y_o));
    check(!busy_bad, "R2 ready low while busy", busy_bad, 0);
    @(negedge clk);
    check(valid_o == 1'b0, "R3 strobe one cycle", valid_o, 0);
    check(ready_o == 1'b1, "R2 ready after strobe", ready_o, 1);
  endtask

  task automatic run_acc(input real x, input string tag);
    int code, y, lat, e, d;
    code = to_code(x);
    run(code, 1'b0, y, lat);
    e = exp_tanh(code);
    d = y - e;
    check(d <= 4 && d >= -4, {tag, " R5 accuracy"}, y, e);
    check(lat == exp_lat(code), {tag, " R10 R4 latency"}, lat, exp_lat(code));
    check(y <= MAXC && y >= -MAXC, {tag, " R8 range"}, y, MAXC);
  endtask

  task automatic t_reset();
    check(ready_o == 1'b1, "R2 ready after reset", ready_o, 1);
    check(valid_o == 1'b0, "R9 valid low after reset", valid_o, 0);
    check(y_o == '0, "R9 result zero after reset", y_o, 0);
  endtask

  task automatic t_small();
    run_acc(0.0, "zero");
    run_acc(0.1, "small+");
    run_acc(0.25, "quarter");
    run_acc(-0.3, "small-");
    run_acc(0.33, "edge");
  endtask

  task automatic t_reduce();
    run_acc(1.0, "one");
    run_acc(-2.0, "minus two");
    run_acc(3.5, "three.5");
    run_acc(5.0, "five");
    run_acc(-4.2, "minus 4.2");
  endtask

  task automatic t_sym();
    int yp, yn, lat;
    run(to_code(0.7), 1'b0, yp, lat);
    run(to_code(-0.7), 1'b0, yn, lat);
    check(yp == -yn, "R6 odd symmetry 0.7", yn, -yp);
    run(to_code(2.5), 1'b0, yp, lat);
    run(to_code(-2.5), 1'b0, yn, lat);
    check(yp == -yn, "R6 odd symmetry 2.5", yn, -yp);
  endtask

  task automatic t_sat();
    int y, lat;
    run(to_code(6.0), 1'b0, y, lat);
    check(y == MAXC, "R7 saturate +6", y, MAXC);
    check(lat == 2, "R7 saturate latency", lat, 2);
    run(to_code(-6.0), 1'b0, y, lat);
    check(y == -MAXC, "R7 saturate -6", y, -MAXC);
    run(32767, 1'b0, y, lat);
    check(y == MAXC, "R7 R8 saturate max code", y, MAXC);
    run(-32768, 1'b0, y, lat);
    check(y == -MAXC, "R7 R8 saturate min code", y, -MAXC);
    check(lat == 2, "R7 saturate latency min", lat, 2);
  endtask

  task automatic t_drop();
    int y_ref, y, lat;
    bit extra = 1'b0;
    run(to_code(0.5), 1'b0, y_ref, lat);
    run(to_code(0.5), 1'b1, y, lat);
    check(y == y_ref, "R1 busy pulse ignored, result", y, y_ref);
    check(lat == exp_lat(to_code(0.5)), "R1 busy pulse ignored, latency", lat, exp_lat(to_code(0.5)));
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (valid_o || !ready_o) extra = 1'b1;
    end
    check(!extra, "R1 no computation from dropped pulse", extra, 0);
  endtask

  task automatic t_hold();
    int y, lat;
    bit moved = 1'b0;
    run(to_code(-1.3), 1'b0, y, lat);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (int'($signed(y_o)) != y || valid_o) moved = 1'b1;
    end
    check(!moved, "R9 result held between strobes", moved, 0);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_reduce();
    t_sym();
    t_sat();
    t_drop();
    t_hold();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule